// File: doc/BRIEF.md
# Selectable-Ratio Sample Demultiplexer

This block accepts one sample per clock, made of a 10-bit code and an out-of-range flag, and spreads consecutive samples across four parallel output ports A, B, C and D. Each port then runs at a quarter or at half of the input rate. In the by-2 setting only ports A and B carry data. The assembled words leave in parallel once per group. An optional Gray coding of the code field, a data-ready clock with two rate modes, and a staggered timing mode complete the output side. In staggered mode the odd ports trail the even ones by half a group period, and each port's out-of-range output turns into a clock that belongs to that port.

An asynchronous reset clears every output at once. Its release is synchronised to the clock, and the first sample accepted after release always lands on port A. The ratio, staggering, coding and clock-mode selects are treated as static and are changed only while reset is held.

Top module: `spread_demux`

## Requirements
- R1: Code and out-of-range flag of one sample always reach the same port. In simultaneous mode each port's `port_aux` bit shows the flag of the sample on that port.
- R2: With `ratio_full`=1, sample k of a group goes to port k (A=0 … D=3) in arrival order. All four ports update together on the clock edge that accepts the fourth sample, and they update again every 4 clocks.
- R3: With `ratio_full`=0, ports A and B take samples in order and update every 2 clocks. Ports C and D keep their code and aux values unchanged; after reset these values are 0.
- R4: Driving `arst_n` low clears all codes, aux bits, `grp_valid` and `dr_clk` without waiting for a clock. After release, the sample present at the third rising edge is the first one accepted, and it goes to port A.
- R5: `grp_valid` is 0 until the first complete group appears on the ports, then stays 1 until the next reset.
- R6: With `gray_sel`=1, each port code equals b XOR (b>>1), where b is the binary input code. With `gray_sel`=0 the code passes unchanged. The out-of-range flag is never recoded.
- R7: With `drclk_half`=0, `dr_clk` rises on the edge where a group loads. It stays high for the first half of the group period and low for the second half. It is 0 before the first group.
- R8: With `drclk_half`=1, `dr_clk` toggles on every group load, so both of its edges mark new data. It is 0 before the first group.
- R9: With `stagger_en`=0, every active port updates on the same clock edge.
- R10: With `stagger_en`=1, even ports (A, C) update on the group edge. Odd ports (B, D) show the same group's words half a group period later: 2 clocks at ratio 4, 1 clock at ratio 2.
- R11: With `stagger_en`=1, each port's `port_aux` bit is that port's clock. It starts at 0 after reset and toggles each time that port's word updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| arst_n | input | 1 | Asynchronous active-low reset, release synchronised internally |
| smp_code | input | CODE_W | Incoming sample code, binary |
| smp_ovr | input | 1 | Out-of-range flag of the incoming sample |
| ratio_full | input | 1 | 1 = spread over four ports, 0 = over two |
| gray_sel | input | 1 | 1 = Gray-coded output codes |
| stagger_en | input | 1 | 1 = odd ports trail by half a group period |
| drclk_half | input | 1 | 1 = data-ready clock at half the group rate, both edges active |
| port_code | output | NUM_PORTS*CODE_W | Port codes, port A in the lowest CODE_W bits |
| port_aux | output | NUM_PORTS | Per-port out-of-range flag, or per-port clock in staggered mode |
| grp_valid | output | 1 | High once the first group has been presented |
| dr_clk | output | 1 | Data-ready clock |

## Verification
Assertions check several things on every cycle. The slot counter must wrap to port A after the last slot. The valid flag must be sticky and may rise only on a group edge. In half-rate mode the data-ready clock must toggle only on group loads. Idle upper ports must hold in the by-2 setting. Odd ports must move with even ports when simultaneous, and only on the mid-group edge when staggered. Reset release must follow the asynchronous input. Other behaviour can only be shown by the bench's scenarios, because it needs the input stream the bench drives: which sample ends up on which port, the Gray values, the first-sample-on-A alignment after a fresh reset, the high and low phases of the full-rate clock, and the per-port clock sequence.

// File: rtl/sdx_pkg.sv
`timescale 1ns/1ps
package sdx_pkg;

   typedef enum logic {RATIO_HALF = 1'b0, RATIO_FULL = 1'b1} ratio_e;
   typedef enum logic {DRK_RATE = 1'b0, DRK_HALF = 1'b1}     drk_e;

   // number of ports in use for the selected ratio
   function automatic int unsigned lane_count(input logic full, input int unsigned nports);
      return (ratio_e'(full) == RATIO_FULL) ? nports : nports / 2;
   endfunction

endpackage

// File: rtl/sdx_rst_sync.sv
`timescale 1ns/1ps
module sdx_rst_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic srst_n
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sdx_rst_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
   end

   assign srst_n = chain_q[STAGES-1];

   // R4: release only ever follows a released asynchronous input
   p_release_sync_r4: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(srst_n) |-> $past(arst_n));

endmodule

// File: rtl/sdx_coder.sv
`timescale 1ns/1ps
module sdx_coder #(
   parameter int unsigned CODE_W  = 10,
   parameter bit          GRAY_EN = 1'b1
) (
   input  logic              gray_sel,
   input  logic [CODE_W-1:0] code_in,
   output logic [CODE_W-1:0] code_out
);

   if (CODE_W < 2) begin : g_bad_width
      $error("sdx_coder: CODE_W must be at least 2");
   end

   if (GRAY_EN) begin : g_gray
      logic [CODE_W-1:0] reflected;
      assign reflected = code_in ^ (code_in >> 1);
      assign code_out  = gray_sel ? reflected : code_in;
   end else begin : g_plain
      logic sel_unused;
      assign sel_unused = gray_sel;
      assign code_out   = code_in;
   end

endmodule

// File: rtl/sdx_gather.sv
`timescale 1ns/1ps
module sdx_gather import sdx_pkg::*; #(
   parameter int unsigned CODE_W    = 10,
   parameter int unsigned NUM_PORTS = 4
) (
   input  logic                            clk,
   input  logic                            srst_n,
   input  logic                            full_ratio,
   input  logic [CODE_W:0]                 word_in,
   output logic                            last,
   output logic                            mid,
   output logic [NUM_PORTS*(CODE_W+1)-1:0] group_flat
);

   localparam int unsigned W1 = CODE_W + 1;
   localparam int unsigned CW = $clog2(NUM_PORTS);

   logic [CW-1:0] slot_q;
   logic [CW-1:0] last_idx;
   logic [CW-1:0] mid_idx;

   assign last_idx = CW'(lane_count(full_ratio, NUM_PORTS) - 1);
   assign mid_idx  = CW'(lane_count(full_ratio, NUM_PORTS) / 2 - 1);
   assign last     = (slot_q >= last_idx);
   assign mid      = (slot_q == mid_idx);

   always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n)   slot_q <= '0;
      else if (last) slot_q <= '0;
      else           slot_q <= slot_q + 1'b1;
   end

   // one staging register per port; the slot being filled is bypassed
   for (genvar i = 0; i < NUM_PORTS; i++) begin : g_slot
      logic [W1-1:0] stage_q;
      always_ff @(posedge clk or negedge srst_n) begin
         if (!srst_n)                 stage_q <= '0;
         else if (slot_q == CW'(i))   stage_q <= word_in;
      end
      assign group_flat[i*W1 +: W1] = (slot_q == CW'(i)) ? word_in : stage_q;
   end

   // R2: after the last slot of a group the next sample goes to port A
   p_wrap_to_a_r2: assert property (@(posedge clk) disable iff (!srst_n)
      last |=> (slot_q == '0));

endmodule

// File: rtl/sdx_drive.sv
`timescale 1ns/1ps
module sdx_drive import sdx_pkg::*; #(
   parameter int unsigned CODE_W    = 10,
   parameter int unsigned NUM_PORTS = 4
) (
   input  logic                            clk,
   input  logic                            srst_n,
   input  logic                            full_ratio,
   input  logic                            stagger,
   input  logic                            dr_half,
   input  logic                            last,
   input  logic                            mid,
   input  logic [NUM_PORTS*(CODE_W+1)-1:0] group_flat,
   output logic [NUM_PORTS*CODE_W-1:0]     code_flat,
   output logic [NUM_PORTS-1:0]            aux,
   output logic                            valid,
   output logic                            dr_clk
);

   localparam int unsigned W1   = CODE_W + 1;
   localparam int unsigned HALF = NUM_PORTS / 2;

   logic [NUM_PORTS-1:0] active;
   logic [NUM_PORTS-1:0] tog;

   for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
      logic [W1-1:0] w_q;
      logic          t_q;

      if (i < HALF) begin : g_low
         assign active[i] = 1'b1;
      end else begin : g_high
         assign active[i] = full_ratio;
      end

      if ((i % 2) == 0) begin : g_even
         always_ff @(posedge clk or negedge srst_n) begin
            if (!srst_n) begin
               w_q <= '0;
               t_q <= 1'b0;
            end else if (last && active[i]) begin
               w_q <= group_flat[i*W1 +: W1];
               t_q <= ~t_q;
            end
         end
      end else begin : g_odd
         logic [W1-1:0] shadow_q;
         logic          armed_q;
         logic          load_now;

         assign load_now = stagger ? (mid && armed_q) : last;

         always_ff @(posedge clk or negedge srst_n) begin
            if (!srst_n) begin
               shadow_q <= '0;
               armed_q  <= 1'b0;
               w_q      <= '0;
               t_q      <= 1'b0;
            end else begin
               if (last && active[i]) begin
                  shadow_q <= group_flat[i*W1 +: W1];
                  armed_q  <= 1'b1;
               end
               if (load_now && active[i]) begin
                  w_q <= stagger ? shadow_q : group_flat[i*W1 +: W1];
                  t_q <= ~t_q;
               end
            end
         end
      end

      assign tog[i]                       = t_q;
      assign code_flat[i*CODE_W +: CODE_W] = w_q[CODE_W-1:0];
      assign aux[i]                       = stagger ? t_q : w_q[CODE_W];
   end

   always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) begin
         valid  <= 1'b0;
         dr_clk <= 1'b0;
      end else begin
         if (last) valid <= 1'b1;
         if (drk_e'(dr_half) == DRK_HALF) begin
            if (last) dr_clk <= ~dr_clk;
         end else if (last) begin
            dr_clk <= 1'b1;
         end else if (mid) begin
            dr_clk <= 1'b0;
         end
      end
   end

   // R5: once presented, the valid flag stays high
   p_valid_sticky_r5: assert property (@(posedge clk) disable iff (!srst_n)
      valid |=> valid);

   // R5: valid rises only on a group edge
   p_valid_on_group_r5: assert property (@(posedge clk) disable iff (!srst_n)
      $rose(valid) |-> $past(last));

   // R8: half-rate clock flips on each group load and holds otherwise
   p_dr_toggle_r8: assert property (@(posedge clk) disable iff (!srst_n)
      (dr_half && last) |=> (dr_clk != $past(dr_clk)));
   p_dr_hold_r8: assert property (@(posedge clk) disable iff (!srst_n)
      (dr_half && !last) |=> $stable(dr_clk));

   // R3: upper ports do not move in the by-2 setting
   p_idle_hold_r3: assert property (@(posedge clk) disable iff (!srst_n)
      !full_ratio |=> $stable(code_flat[NUM_PORTS*CODE_W-1:HALF*CODE_W]) && $stable(aux[NUM_PORTS-1:HALF]));

   // R9: simultaneous mode moves port B together with port A
   p_same_edge_r9: assert property (@(posedge clk) disable iff (!srst_n)
      !stagger |=> ((tog[1] ^ $past(tog[1])) == (tog[0] ^ $past(tog[0]))));

   // R10: staggered mode moves port B only on the mid-group edge
   p_odd_mid_r10: assert property (@(posedge clk) disable iff (!srst_n)
      (stagger && !mid) |=> $stable(tog[1]));

endmodule

// File: rtl/spread_demux.sv
`timescale 1ns/1ps
module spread_demux import sdx_pkg::*; #(
   parameter int unsigned CODE_W      = 10,
   parameter int unsigned NUM_PORTS   = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          GRAY_EN     = 1'b1
) (
   input  logic                        clk,
   input  logic                        arst_n,
   input  logic [CODE_W-1:0]           smp_code,
   input  logic                        smp_ovr,
   input  logic                        ratio_full,
   input  logic                        gray_sel,
   input  logic                        stagger_en,
   input  logic                        drclk_half,
   output logic [NUM_PORTS*CODE_W-1:0] port_code,
   output logic [NUM_PORTS-1:0]        port_aux,
   output logic                        grp_valid,
   output logic                        dr_clk
);

   localparam int unsigned W1 = CODE_W + 1;

   if (NUM_PORTS < 4 || (NUM_PORTS & (NUM_PORTS - 1)) != 0) begin : g_bad_ports
      $error("spread_demux: NUM_PORTS must be a power of two, at least 4");
   end

   logic                      srst_n;
   logic [CODE_W-1:0]         coded;
   logic                      last;
   logic                      mid;
   logic [NUM_PORTS*W1-1:0]   group_flat;

   sdx_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
      .clk    (clk),
      .arst_n (arst_n),
      .srst_n (srst_n)
   );

   sdx_coder #(.CODE_W(CODE_W), .GRAY_EN(GRAY_EN)) u_coder (
      .gray_sel (gray_sel),
      .code_in  (smp_code),
      .code_out (coded)
   );

   sdx_gather #(.CODE_W(CODE_W), .NUM_PORTS(NUM_PORTS)) u_gather (
      .clk        (clk),
      .srst_n     (srst_n),
      .full_ratio (ratio_full),
      .word_in    ({smp_ovr, coded}),
      .last       (last),
      .mid        (mid),
      .group_flat (group_flat)
   );

   sdx_drive #(.CODE_W(CODE_W), .NUM_PORTS(NUM_PORTS)) u_drive (
      .clk        (clk),
      .srst_n     (srst_n),
      .full_ratio (ratio_full),
      .stagger    (stagger_en),
      .dr_half    (drclk_half),
      .last       (last),
      .mid        (mid),
      .group_flat (group_flat),
      .code_flat  (port_code),
      .aux        (port_aux),
      .valid      (grp_valid),
      .dr_clk     (dr_clk)
   );

endmodule

// File: tb/sim_spread_demux.sv
`timescale 1ns/1ps
module sim_spread_demux;

   localparam int W = 10;
   localparam int N = 4;

   logic           clk = 1'b0;
   logic           arst_n;
   logic [W-1:0]   smp_code;
   logic           smp_ovr;
   logic           ratio_full, gray_sel, stagger_en, drclk_half;
   logic [N*W-1:0] port_code;
   logic [N-1:0]   port_aux;
   logic           grp_valid, dr_clk;

   int n_chk = 0;
   int n_bad = 0;
   int e     = 0;
   int cur_l = 4;
   logic [W:0] smp [0:1023];

   always #2 clk = ~clk;

   spread_demux u0 (
      .clk(clk), .arst_n(arst_n), .smp_code(smp_code), .smp_ovr(smp_ovr),
      .ratio_full(ratio_full), .gray_sel(gray_sel), .stagger_en(stagger_en),
      .drclk_half(drclk_half), .port_code(port_code), .port_aux(port_aux),
      .grp_valid(grp_valid), .dr_clk(dr_clk)
   );

   function automatic logic [W-1:0] enc(input logic [W-1:0] b, input logic g);
      return g ? (b ^ (b >> 1)) : b;
   endfunction

   function automatic int groups_at(input int edge_n);
      return (edge_n >= 2) ? (edge_n - 2) / cur_l : 0;
   endfunction

   function automatic logic [W:0] exp_word(input int port, input int g);
      logic [W:0] s;
      if (g < 1) return '0;
      s = smp[3 + (g - 1) * cur_l + port];
      return {s[W], enc(s[W-1:0], gray_sel)};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s edge=%0d actual=%0h expected=%0h", req, e, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   endtask

   task automatic check_cycle();
      for (int i = 0; i < N; i++) begin
         int g;
         logic [W:0] w;
         string rq;
         if (i >= cur_l)                  g = 0;
         else if (stagger_en && (i % 2))  g = groups_at(e - cur_l / 2);
         else                             g = groups_at(e);
         w = exp_word(i, g);
         if (i >= cur_l)                  rq = "R3 idle port";
         else if (stagger_en && (i % 2))  rq = "R10 odd port";
         else if (gray_sel)               rq = "R6 gray code";
         else if (cur_l == 4)             rq = "R2 port order";
         else                             rq = "R3 two-port order";
         check(rq, 32'(port_code[i*W +: W]), 32'(w[W-1:0]));
         if (i >= cur_l)   check("R3 idle aux", 32'(port_aux[i]), 32'd0);
         else if (stagger_en) check("R11 port clock", 32'(port_aux[i]), 32'(g % 2));
         else              check("R1 flag with code", 32'(port_aux[i]), 32'(w[W]));
      end
      check("R5 valid", 32'(grp_valid), 32'(groups_at(e) >= 1));
      if (drclk_half) begin
         check("R8 half-rate clock", 32'(dr_clk), 32'(groups_at(e) % 2));
      end else begin
         int k;
         k = e - 2;
         check("R7 full-rate clock", 32'(dr_clk), 32'((k >= cur_l) && ((k % cur_l) < cur_l / 2)));
      end
   endtask

   function automatic logic [W:0] gen(input int c);
      if (c % 7 == 0)  return {1'b1, {W{1'b1}}};
      if (c % 11 == 0) return '0;
      if (c % 13 == 0) return {1'b0, 1'b1, {(W-1){1'b0}}};
      return (W+1)'($urandom);
   endfunction

   task automatic run(input logic full, input logic gray, input logic stag,
                      input logic half, input int ncyc);
      @(negedge clk);
      #0.5 arst_n = 1'b0;
      #0.5;
      // R4: clear without a clock edge
      check("R4 async clear codes", 32'(port_code), 32'd0);
      check("R4 async clear aux", 32'(port_aux), 32'd0);
      check("R4 async clear valid", 32'({grp_valid, dr_clk}), 32'd0);
      ratio_full = full;
      gray_sel   = gray;
      stagger_en = stag;
      drclk_half = half;
      cur_l      = full ? 4 : 2;
      @(negedge clk);
      @(negedge clk);
      arst_n = 1'b1;
      e = 0;
      smp[1] = gen(1);
      {smp_ovr, smp_code} = smp[1];
      for (int c = 1; c <= ncyc; c++) begin
         @(negedge clk);
         e = c;
         check_cycle();
         smp[c + 1] = gen(c + 1);
         {smp_ovr, smp_code} = smp[c + 1];
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      void'($urandom(32'h5EED));
      arst_n = 1'b0;
      smp_code = '0;
      smp_ovr = 1'b0;
      ratio_full = 1'b1;
      gray_sel = 1'b0;
      stagger_en = 1'b0;
      drclk_half = 1'b0;
      // directed corner configurations
      run(1'b1, 1'b0, 1'b0, 1'b0, 40);  // R2 R7 R9 R1
      run(1'b1, 1'b1, 1'b1, 1'b1, 40);  // R6 R8 R10 R11
      run(1'b0, 1'b0, 1'b1, 1'b0, 40);  // R3 R10 R7
      run(1'b0, 1'b1, 1'b0, 1'b1, 40);  // R3 R6 R8 R4
      // random configurations
      for (int r = 0; r < 8; r++) begin
         logic [3:0] cfg;
         cfg = 4'($urandom);
         run(cfg[0], cfg[1], cfg[2], cfg[3], 20 + int'($urandom % 40));
      end
      finish_up();
   end

endmodule